// File: doc/BRIEF.md
# Dual-Output PWM Timebase Generator

The block produces two pulse-width-modulated signals from one shared 16-bit timebase. A prescaler divides the input clock in two stages. The first stage divides by a power of two. The second stage divides by 1 or by an even ratio up to 14. The product of the two stages sets how often the timebase steps. The timebase counts up, counts down, counts up and down, or holds. Its turning point is set by a period register.

Each output has its own compare register and its own pair of action codes. One code applies when the timebase arrives at zero. The other applies when the timebase reaches the compare value on an upward step. An action can leave the pin alone, drive it low, drive it high, or invert it. Software programs the block through a single-cycle write strobe with a 3-bit register address and 16-bit data. This write port can also load the timebase directly, for example to restart a waveform from zero.

Top module: `pwm_timebase_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first write, the timebase reads 0, both outputs are low, and the timebase does not move, because the control register comes out of reset in hold mode.
- R2: Control bits [12:10] (code k) set a first-stage divide of 2^k.
- R3: Control bits [9:7] (code k) set a second-stage divide of 1 for k = 0 and 2k otherwise. The timebase steps once every (first ratio × second ratio) input clocks.
- R4: With control bits [1:0] = 0 (up), the timebase rises by one each step and goes to 0 on the step after it has reached the period.
- R5: With control bits [1:0] = 1 (down), the timebase falls by one each step and reloads the period on the step after it has reached 0.
- R6: With control bits [1:0] = 2 (up-down), the timebase rises to the period, then falls back to 0, then rises again. In this mode it never exceeds the period once it is at or below it.
- R7: With control bits [1:0] = 3 (hold), the timebase and both outputs keep their values.
- R8: A write to address 4 loads the timebase with the written value on the next clock. That write triggers no output action, even if the loaded value is 0 or equals a compare value.
- R9: Action codes are 0 = keep, 1 = low, 2 = high, 3 = invert. Bits [1:0] of the action register for output A (address 5) and of the action register for output B (address 6) give the action taken on the step where the timebase arrives at 0.
- R10: The compare action comes from bits [5:4] for output A and bits [9:8] for output B. It fires only on an upward step that lands on that output's compare value: every step in up mode, and the rising steps in up-down mode. It never fires in down mode.
- R11: When the zero event and the compare event fall on the same step, the compare action is used.
- R12: Writing the control register restarts the prescaler, so the first step after that write comes exactly one full division later.
- R13: The register addresses are 0 = control, 1 = period, 2 = compare A, 3 = compare B, 4 = timebase, 5 = action A, 6 = action B. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current timebase value |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |

## Verification
The stepping properties assume a cycle has no write of any kind before they claim anything about the next timebase value. A write to the period, to the mode or to the timebase itself would legitimately change the outcome. The stimulus therefore programs every register while the timebase is held. It then releases the timebase with a single control write and leaves the port idle while waveforms run. The up-down bound assumes the timebase starts at or below the period. The bench ensures this by always loading 0 before switching to that mode.

// File: rtl/pwm_gen_pkg.sv
`timescale 1ns/1ps
package pwm_gen_pkg;

    localparam int ADDR_W = 3;
    localparam int PRE_W  = 11;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRD   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP_A = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_ACT_A = 3'd5;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } act_e;

    typedef struct packed {
        act_e on_zero;
        act_e on_cmp;
    } act_cfg_t;

    function automatic int unsigned stage1_ratio(input logic [2:0] code);
        return 32'd1 << code;
    endfunction

    function automatic int unsigned stage2_ratio(input logic [2:0] code);
        return (code == 3'd0) ? 32'd1 : 32'd2 * 32'(code);
    endfunction

    function automatic int cmp_field_lsb(input int idx);
        return (idx == 0) ? 4 : 8;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
    import pwm_gen_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel1,
    input  logic [2:0] sel2,
    output logic       tick
);

    logic [PW-1:0] div_d, div_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = PW'(stage1_ratio(sel1) * stage2_ratio(sel2) - 32'd1);
        tick  = (div_q >= limit);
        if (restart || tick) div_d = '0;
        else                 div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
    import pwm_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] period,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx,
    output logic          advance,
    output logic          rising
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dir_up;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        advance = 1'b0;
        rising  = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick && mode != MODE_HOLD) begin
            advance = 1'b1;
            case (mode)
                MODE_UP: begin
                    rising   = 1'b1;
                    st_d.cnt = (st_q.cnt >= period) ? '0 : st_q.cnt + 1'b1;
                end
                MODE_DOWN: begin
                    st_d.cnt = (st_q.cnt == '0) ? period : st_q.cnt - 1'b1;
                end
                MODE_UPDN: begin
                    if (st_q.dir_up) begin
                        if (st_q.cnt >= period) begin
                            st_d.dir_up = 1'b0;
                            st_d.cnt    = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                        end else begin
                            rising   = 1'b1;
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else if (st_q.cnt == '0) begin
                        st_d.dir_up = 1'b1;
                        if (period != '0) begin
                            rising   = 1'b1;
                            st_d.cnt = CW'(1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
        cnt    = st_q.cnt;
        cnt_nx = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, dir_up: 1'b1};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_action.sv
`timescale 1ns/1ps
module pwm_action
    import pwm_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          rising,
    input  logic [CW-1:0] cnt_nx,
    input  logic [CW-1:0] cmp,
    input  act_cfg_t      cfg,
    output logic          pwm
);

    act_e code;
    logic pwm_d, pwm_q;

    always_comb begin
        code = ACT_KEEP;
        if (advance) begin
            if (rising && cnt_nx == cmp) code = cfg.on_cmp;
            else if (cnt_nx == '0)       code = cfg.on_zero;
        end
        case (code)
            ACT_LOW:  pwm_d = 1'b0;
            ACT_HIGH: pwm_d = 1'b1;
            ACT_FLIP: pwm_d = ~pwm_q;
            default:  pwm_d = pwm_q;
        endcase
        pwm = pwm_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

endmodule

// File: rtl/pwm_timebase_gen.sv
`timescale 1ns/1ps
module pwm_timebase_gen
    import pwm_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic [CW-1:0]     count_o,
    output logic              pwm_a_o,
    output logic              pwm_b_o
);

    localparam int NOUT = 2;

    typedef struct packed {
        cnt_mode_e                mode;
        logic [2:0]               sel1;
        logic [2:0]               sel2;
        logic [CW-1:0]            period;
        logic [NOUT-1:0][CW-1:0]  cmp;
        act_cfg_t [NOUT-1:0]      act;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          pre_tick;
    logic          restart, load;
    logic [CW-1:0] cnt_nx;
    logic          advance, rising;
    logic [NOUT-1:0] pwm;

    always_comb begin
        regs_d  = regs_q;
        restart = wr_en && (wr_addr == ADDR_CTRL);
        load    = wr_en && (wr_addr == ADDR_CNT);
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                regs_d.mode = cnt_mode_e'(wr_data[1:0]);
                regs_d.sel2 = wr_data[9:7];
                regs_d.sel1 = wr_data[12:10];
            end
            if (wr_addr == ADDR_PRD) regs_d.period = CW'(wr_data);
            for (int g = 0; g < NOUT; g++) begin
                if (wr_addr == ADDR_W'(ADDR_CMP_A + g))
                    regs_d.cmp[g] = CW'(wr_data);
                if (wr_addr == ADDR_W'(ADDR_ACT_A + g)) begin
                    regs_d.act[g].on_zero = act_e'(wr_data[1:0]);
                    regs_d.act[g].on_cmp  = act_e'(wr_data[cmp_field_lsb(g) +: 2]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.mode <= MODE_HOLD;
        end else begin
            regs_q <= regs_d;
        end
    end

    pwm_prescaler #(.PW(PRE_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel1    (regs_q.sel1),
        .sel2    (regs_q.sel2),
        .tick    (pre_tick)
    );

    pwm_counter #(.CW(CW)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (pre_tick),
        .mode     (regs_q.mode),
        .period   (regs_q.period),
        .load     (load),
        .load_val (CW'(wr_data)),
        .cnt      (count_o),
        .cnt_nx   (cnt_nx),
        .advance  (advance),
        .rising   (rising)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        pwm_action #(.CW(CW)) i_act (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (advance),
            .rising  (rising),
            .cnt_nx  (cnt_nx),
            .cmp     (regs_q.cmp[g]),
            .cfg     (regs_q.act[g]),
            .pwm     (pwm[g])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];

endmodule

// File: rtl/pwm_timebase_chk.sv
`timescale 1ns/1ps
module pwm_timebase_chk
    import pwm_gen_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [CW-1:0]     count_o,
    input logic              pwm_a_o,
    input logic              pwm_b_o,
    input cnt_mode_e         mode,
    input logic [CW-1:0]     period,
    input logic              tick
);

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && !wr_en) |=> ($stable(count_o) && $stable(pwm_a_o) && $stable(pwm_b_o)));

    assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CNT) |=> (count_o == CW'($past(wr_data))));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && !wr_en && count_o < period) |=> (count_o == $past(count_o) + CW'(1)));

    assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DOWN && !wr_en && count_o != '0) |=> (count_o == $past(count_o) - CW'(1)));

    assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DOWN && !wr_en && count_o == '0) |=> (count_o == $past(period)));

    assert_updn_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDN && !wr_en && count_o <= period) |=> (count_o <= period));

endmodule

bind pwm_timebase_gen pwm_timebase_chk #(.CW(CW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_o (count_o),
    .pwm_a_o (pwm_a_o),
    .pwm_b_o (pwm_b_o),
    .mode    (regs_q.mode),
    .period  (regs_q.period),
    .tick    (pre_tick)
);

// File: tb/test_pwm_timebase_gen.sv
`timescale 1ns/1ps
module test_pwm_timebase_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        pwm_a_o, pwm_b_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mdl_on = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwm_timebase_gen i_pwm_timebase_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int divisor(input int s1, input int s2);
        return (1 << s1) * ((s2 == 0) ? 1 : 2 * s2);
    endfunction

    // Reference model built from the requirements
    int        m_cnt, m_prd, m_pre, m_s1, m_s2, m_mode;
    bit        m_dir;
    int        m_cmp[2];
    int        m_az[2];
    int        m_ac[2];
    bit        m_pwm[2];

    always @(posedge clk or negedge rst_n) begin : model
        int dv, nx, code;
        bit tk, adv, up;
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_pre = 0; m_s1 = 0; m_s2 = 0; m_mode = 3; m_dir = 1;
            for (int o = 0; o < 2; o++) begin
                m_cmp[o] = 0; m_az[o] = 0; m_ac[o] = 0; m_pwm[o] = 0;
            end
        end else begin
            dv = divisor(m_s1, m_s2);
            tk = (m_pre == dv - 1);
            adv = 0; up = 0; nx = m_cnt;
            if (wr_en && wr_addr == 3'd4) nx = int'(wr_data);
            else if (tk && m_mode != 3) begin
                adv = 1;
                if (m_mode == 0) begin
                    up = 1; nx = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
                end else if (m_mode == 1) begin
                    nx = (m_cnt == 0) ? m_prd : m_cnt - 1;
                end else if (m_dir) begin
                    if (m_cnt >= m_prd) begin m_dir = 0; nx = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else begin up = 1; nx = m_cnt + 1; end
                end else if (m_cnt == 0) begin
                    m_dir = 1;
                    if (m_prd != 0) begin up = 1; nx = 1; end
                end else nx = m_cnt - 1;
            end
            if (adv) begin
                for (int o = 0; o < 2; o++) begin
                    code = 0;
                    if (up && nx == m_cmp[o]) code = m_ac[o];
                    else if (nx == 0)         code = m_az[o];
                    if (code == 1) m_pwm[o] = 0;
                    else if (code == 2) m_pwm[o] = 1;
                    else if (code == 3) m_pwm[o] = !m_pwm[o];
                end
            end
            m_cnt = nx;
            m_pre = (wr_en && wr_addr == 3'd0) ? 0 : (tk ? 0 : m_pre + 1);
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_mode = int'(wr_data[1:0]); m_s2 = int'(wr_data[9:7]); m_s1 = int'(wr_data[12:10]); end
                    3'd1: m_prd = int'(wr_data);
                    3'd2: m_cmp[0] = int'(wr_data);
                    3'd3: m_cmp[1] = int'(wr_data);
                    3'd5: begin m_az[0] = int'(wr_data[1:0]); m_ac[0] = int'(wr_data[5:4]); end
                    3'd6: begin m_az[1] = int'(wr_data[1:0]); m_ac[1] = int'(wr_data[9:8]); end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (mdl_on && !done) begin
            check(count_o == 16'(m_cnt), cur_req, int'(count_o), m_cnt);
            check(pwm_a_o == m_pwm[0], cur_req, int'(pwm_a_o), int'(m_pwm[0]));
            check(pwm_b_o == m_pwm[1], cur_req, int'(pwm_b_o), int'(m_pwm[1]));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic measure(input int s1, input int s2);
        int lat, per, exp;
        logic [15:0] st;
        exp = divisor(s1, s2);
        wr(3'd0, 16'h0003);
        wr(3'd1, 16'hFFFF);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'((s1 << 10) | (s2 << 7)));
        st = count_o; lat = 0;
        do begin @(negedge clk); lat++; end while (count_o == st && lat < 4000);
        check(lat == exp, "R12", lat, exp);
        st = count_o; per = 0;
        do begin @(negedge clk); per++; end while (count_o == st && per < 4000);
        check(per == exp, (s2 == 0) ? "R2" : "R3", per, exp);
    endtask

    task automatic run_mode(input int md, input int prd, input int ca, input int cb,
                            input logic [15:0] aa, input logic [15:0] ab);
        wr(3'd0, 16'h0003);
        wr(3'd1, 16'(prd));
        wr(3'd2, 16'(ca));
        wr(3'd3, 16'(cb));
        wr(3'd5, aa);
        wr(3'd6, ab);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'(md));
        repeat (6 * (prd + 1) + 6) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int plist[4];
        logic [15:0] st;
        bit pa, pb, b1;
        plist = '{0, 1, 4, 9};

        // R1: reset values
        repeat (3) @(negedge clk);
        check(count_o == 0, "R1", int'(count_o), 0);
        check(pwm_a_o == 0 && pwm_b_o == 0, "R1", int'({pwm_a_o, pwm_b_o}), 0);
        rst_n = 1'b1;
        mdl_on = 1;
        repeat (5) @(negedge clk);
        check(count_o == 0, "R1", int'(count_o), 0);

        // R2, R3, R12: divider ratios
        for (int s = 0; s < 8; s++) measure(s, 0);
        for (int s = 1; s < 8; s++) measure(0, s);
        measure(3, 5);
        measure(7, 7);

        // Mode sweeps checked cycle by cycle against the model (R4 R5 R6 R9 R10)
        for (int md = 0; md < 3; md++) begin
            cur_req = (md == 0) ? "R4" : (md == 1) ? "R5" : "R6";
            for (int pi = 0; pi < 4; pi++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    int c;
                    c = (ci == 0) ? 0 : (ci == 1) ? 2 : plist[pi];
                    run_mode(md, plist[pi], c, plist[pi] - c, 16'h0012, 16'h0301);
                    run_mode(md, plist[pi], c, plist[pi] >> 1, 16'h0033, 16'h0202);
                end
            end
        end

        // R10: duty in up mode; R9: zero-event invert on B
        cur_req = "R10";
        wr(3'd0, 16'h0003); wr(3'd1, 16'd7); wr(3'd2, 16'd3);
        wr(3'd5, 16'h0012); wr(3'd6, 16'h0003); wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0000);
        repeat (16) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            check(pwm_a_o == (count_o < 16'd3), "R10", int'(pwm_a_o), int'(count_o < 16'd3));
            @(negedge clk);
        end
        while (count_o != 16'd1) @(negedge clk);
        b1 = pwm_b_o;
        repeat (8) @(negedge clk);
        check(count_o == 16'd1, "R9", int'(count_o), 1);
        check(pwm_b_o == !b1, "R9", int'(pwm_b_o), int'(!b1));

        // R10: no compare action in down mode
        cur_req = "R10";
        wr(3'd0, 16'h0003); wr(3'd5, 16'h0030); wr(3'd4, 16'h0000);
        pa = pwm_a_o;
        wr(3'd0, 16'h0001);
        repeat (40) @(negedge clk);
        check(pwm_a_o == pa, "R10", int'(pwm_a_o), int'(pa));

        // R11: compare beats zero when compare value is 0
        cur_req = "R11";
        wr(3'd0, 16'h0003); wr(3'd1, 16'd4); wr(3'd2, 16'd0);
        wr(3'd5, 16'h0012); wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0000);
        repeat (12) @(negedge clk);
        while (count_o != 16'd0) @(negedge clk);
        check(pwm_a_o == 1'b0, "R11", int'(pwm_a_o), 0);

        // R8: load without action
        cur_req = "R8";
        wr(3'd0, 16'h0003); wr(3'd1, 16'd9); wr(3'd2, 16'd7);
        wr(3'd5, 16'h0033); wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0000);
        while (count_o != 16'd2) @(negedge clk);
        pa = pwm_a_o;
        wr(3'd4, 16'd7);
        check(count_o == 16'd7, "R8", int'(count_o), 7);
        check(pwm_a_o == pa, "R8", int'(pwm_a_o), int'(pa));
        pa = pwm_a_o;
        wr(3'd4, 16'd0);
        check(count_o == 16'd0, "R8", int'(count_o), 0);
        check(pwm_a_o == pa, "R8", int'(pwm_a_o), int'(pa));

        // R7: hold freezes timebase and outputs
        cur_req = "R7";
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h0003);
        st = count_o; pa = pwm_a_o; pb = pwm_b_o;
        repeat (20) @(negedge clk);
        check(count_o == st, "R7", int'(count_o), int'(st));
        check(pwm_a_o == pa && pwm_b_o == pb, "R7", int'({pwm_a_o, pwm_b_o}), int'({pa, pb}));

        // R13: unused address has no effect
        cur_req = "R13";
        wr(3'd7, 16'hFFFF);
        repeat (3) @(negedge clk);
        check(count_o == st, "R13", int'(count_o), int'(st));
        check(pwm_a_o == pa && pwm_b_o == pb, "R13", int'({pwm_a_o, pwm_b_o}), int'({pa, pb}));
        wr(3'd0, 16'h0000);
        repeat (30) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule